// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the device-side command decoder of a 16-bit-wide flash memory. A host drives a simple synchronous bus made of a word address, a write data word, a write strobe, a read strobe and a registered read data word. Words written to any address are decoded as commands. Program and erase are each started by two writes: a setup word followed by the data word or the confirm word. A small flip-flop backing array stands in for the flash cells, so programmed words and erased blocks can be read back.

After any command other than the return-to-array command, every read returns the status word at any address. This lasts until the host writes the read-array command. Status bit 7 is the ready flag and status bit 5 flags an aborted erase sequence. A parameterised busy counter stands in for the real program and erase times. The host polls bit 7 until it reads 1, then writes the read-array command to see array data again.

States: `ST_ARRAY` (reads return array data), `ST_STATUS` (reads return status, idle), `ST_PGM_SETUP` (waiting for the data word), `ST_ERS_SETUP` (waiting for the confirm word), `ST_PGM_BUSY` and `ST_ERS_BUSY` (operation running). The transitions are:
- read-array command from `ST_ARRAY` or `ST_STATUS` goes to `ST_ARRAY`;
- clear-status command from those two states goes to `ST_STATUS`;
- program-setup command goes to `ST_PGM_SETUP`;
- erase-setup command goes to `ST_ERS_SETUP`;
- any write in `ST_PGM_SETUP` goes to `ST_PGM_BUSY`;
- confirm in `ST_ERS_SETUP` goes to `ST_ERS_BUSY`;
- any other word in `ST_ERS_SETUP` goes to `ST_STATUS` with the error flag set;
- busy-counter expiry in either busy state goes to `ST_STATUS`.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in read-array mode, every array word reads 0xFFFF and the status word is 0x0080.
- R2: In read-array mode, a read strobe at address A returns the word stored at A on `bus_rdata` in the cycle after the strobe.
- R3: Writing 0x1010 and then a data word D at address A programs the word at A to (old AND D) once the busy time ends.
- R4: Writing 0x2020 and then 0xD0D0 at address A sets every word in the block holding A (2^BLK_W words, block index = upper address bits) to 0xFFFF once the busy time ends, and leaves every other block unchanged.
- R5: A word other than 0xD0D0 written after 0x2020 aborts the erase, leaves the array unchanged, sets status bit 5 and enters status mode.
- R6: Writing 0x5050 in read-array or status mode clears status bit 5 and enters status mode.
- R7: Writing 0xFFFF in read-array or status mode returns the block to read-array mode.
- R8: From any accepted command other than 0xFFFF until 0xFFFF is written, a read at any address returns the status word (bits 15:8 and 4:0 zero, bit 6 zero).
- R9: Status bit 7 reads 0 for exactly BUSY_CYCLES cycles after the cycle holding the data or confirm write, and reads 1 from then on.
- R10: Writes received during a program or erase busy period are ignored; the block still returns to status mode when the busy period ends.
- R11: In read-array or status mode, a written word that is none of 0x5050, 0x1010, 0x2020 or 0xFFFF changes neither mode nor array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data or command word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, data returned next cycle |
| bus_rdata | output | 16 | Registered read data (array word or status) |

## Verification
The bench builds the block with ADDR_W=8, BLK_W=4 and BUSY_CYCLES=5. Blocks of 16 words let it program words on both sides of a block edge and show that an erase stops exactly at the boundary. A five-cycle busy period is short enough to poll the status word on every cycle across it, which checks the exact busy length. It also leaves room to land ignored writes inside the busy window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_STATUS,
        ST_PGM_SETUP,
        ST_ERS_SETUP,
        ST_PGM_BUSY,
        ST_ERS_BUSY
    } fc_state_e;

    localparam logic [15:0] CMD_CLEAR   = 16'h5050;
    localparam logic [15:0] CMD_PROGRAM = 16'h1010;
    localparam logic [15:0] CMD_ERASE   = 16'h2020;
    localparam logic [15:0] CMD_CONFIRM = 16'hD0D0;
    localparam logic [15:0] CMD_READ    = 16'hFFFF;

    localparam int STS_READY_BIT = 7;
    localparam int STS_ABORT_BIT = 5;

    localparam logic [15:0] ERASED_WORD = 16'hFFFF;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign done = run && (cnt_q == ONE);

endmodule

// File: rtl/flash_word_store.sv
module flash_word_store #(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [15:0]       pgm_data,
    input  logic              ers_en,
    input  logic [ADDR_W-1:0] ers_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_word
);
    import flash_cmd_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [15:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(g);
        logic [15:0] word_q;
        logic        hit_blk;
        logic        hit_word;

        assign hit_blk  = ers_en && (ers_addr[ADDR_W-1:BLK_W] == WADDR[ADDR_W-1:BLK_W]);
        assign hit_word = pgm_en && (pgm_addr == WADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= ERASED_WORD;
            end else if (hit_blk) begin
                word_q <= ERASED_WORD;
            end else if (hit_word) begin
                word_q <= word_q & pgm_data;
            end
        end

        assign words[g] = word_q;
    end

    assign rd_word = words[rd_addr];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [15:0]             wdata,
    input  logic                    op_done,
    output flash_cmd_pkg::fc_state_e state,
    output logic                    op_start,
    output logic                    op_busy,
    output logic                    pgm_en,
    output logic                    ers_en,
    output logic [ADDR_W-1:0]       op_addr,
    output logic [15:0]             op_data,
    output logic [15:0]             status
);
    import flash_cmd_pkg::*;

    fc_state_e         state_q, state_d;
    logic [ADDR_W-1:0] op_addr_q;
    logic [15:0]       op_data_q;
    logic              abort_q;
    logic              idle;
    logic              seq_abort;
    logic              sts_clear;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARRAY;
        end else begin
            state_q <= state_d;
        end
    end

    // Operand latches and abort flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_addr_q <= '0;
            op_data_q <= '0;
            abort_q   <= 1'b0;
        end else begin
            if (op_start) begin
                op_addr_q <= addr;
                op_data_q <= wdata;
            end
            if (seq_abort) begin
                abort_q <= 1'b1;
            end else if (sts_clear) begin
                abort_q <= 1'b0;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARRAY, ST_STATUS: begin
                if (we) begin
                    if (wdata == CMD_READ) begin
                        state_d = ST_ARRAY;
                    end else if (wdata == CMD_CLEAR) begin
                        state_d = ST_STATUS;
                    end else if (wdata == CMD_PROGRAM) begin
                        state_d = ST_PGM_SETUP;
                    end else if (wdata == CMD_ERASE) begin
                        state_d = ST_ERS_SETUP;
                    end
                end
            end
            ST_PGM_SETUP: begin
                if (we) begin
                    state_d = ST_PGM_BUSY;
                end
            end
            ST_ERS_SETUP: begin
                if (we) begin
                    state_d = (wdata == CMD_CONFIRM) ? ST_ERS_BUSY : ST_STATUS;
                end
            end
            ST_PGM_BUSY, ST_ERS_BUSY: begin
                if (op_done) begin
                    state_d = ST_STATUS;
                end
            end
            default: state_d = ST_ARRAY;
        endcase
    end

    // Outputs
    always_comb begin
        idle      = (state_q == ST_ARRAY) || (state_q == ST_STATUS);
        op_busy   = (state_q == ST_PGM_BUSY) || (state_q == ST_ERS_BUSY);
        sts_clear = idle && we && (wdata == CMD_CLEAR);
        seq_abort = (state_q == ST_ERS_SETUP) && we && (wdata != CMD_CONFIRM);
        op_start  = we && ((state_q == ST_PGM_SETUP) ||
                           ((state_q == ST_ERS_SETUP) && (wdata == CMD_CONFIRM)));
        pgm_en    = (state_q == ST_PGM_BUSY) && op_done;
        ers_en    = (state_q == ST_ERS_BUSY) && op_done;
        status                = '0;
        status[STS_READY_BIT] = !op_busy;
        status[STS_ABORT_BIT] = abort_q;
    end

    assign state   = state_q;
    assign op_addr = op_addr_q;
    assign op_data = op_data_q;

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
    parameter int ADDR_W      = 8,
    parameter int BLK_W       = 5,
    parameter int BUSY_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [15:0]       bus_rdata
);
    import flash_cmd_pkg::*;

    fc_state_e         state;
    logic              op_start;
    logic              op_busy;
    logic              op_done;
    logic              pgm_en;
    logic              ers_en;
    logic [ADDR_W-1:0] op_addr;
    logic [15:0]       op_data;
    logic [15:0]       status_w;
    logic [15:0]       arr_word;
    logic [15:0]       rdata_q;

    flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .op_done  (op_done),
        .state    (state),
        .op_start (op_start),
        .op_busy  (op_busy),
        .pgm_en   (pgm_en),
        .ers_en   (ers_en),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .status   (status_w)
    );

    flash_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (op_start),
        .run   (op_busy),
        .done  (op_done)
    );

    flash_word_store #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (pgm_en),
        .pgm_addr (op_addr),
        .pgm_data (op_data),
        .ers_en   (ers_en),
        .ers_addr (op_addr),
        .rd_addr  (bus_addr),
        .rd_word  (arr_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_re) begin
            rdata_q <= (state == ST_ARRAY) ? arr_word : status_w;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_we,
    input logic                     bus_re,
    input logic [15:0]              bus_wdata,
    input logic [15:0]              bus_rdata,
    input flash_cmd_pkg::fc_state_e state,
    input logic                     op_done,
    input logic [15:0]              status,
    input logic                     pgm_en,
    input logic                     ers_en
);
    import flash_cmd_pkg::*;

    logic busy;
    logic idle;
    assign busy = (state == ST_PGM_BUSY) || (state == ST_ERS_BUSY);
    assign idle = (state == ST_ARRAY) || (state == ST_STATUS);

    p_commit_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_en, ers_en}));

    p_bad_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERS_SETUP && bus_we && bus_wdata != CMD_CONFIRM)
        |=> (state == ST_STATUS && status[STS_ABORT_BIT]));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && bus_we && bus_wdata == CMD_CLEAR)
        |=> (state == ST_STATUS && !status[STS_ABORT_BIT]));

    p_read_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && bus_we && bus_wdata == CMD_READ) |=> (state == ST_ARRAY));

    p_busy_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && busy) |=> (bus_rdata[15:8] == 8'h00 && !bus_rdata[7]));

    p_ready_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && state == ST_STATUS) |=> bus_rdata[7]);

    p_done_to_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (state == ST_STATUS));

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done) |=> (state == $past(state)));

endmodule

bind flash_cmd_if flash_cmd_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .state     (state),
    .op_done   (op_done),
    .status    (status_w),
    .pgm_en    (pgm_en),
    .ers_en    (ers_en)
);

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;
    localparam int ADDR_W = 8;
    localparam int BLK_W  = 4;
    localparam int BUSY   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [15:0]       bus_rdata;

    int total = 0;
    int bad = 0;
    logic rd_pend = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    flash_cmd_if #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUSY_CYCLES(BUSY)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) rd_pend <= bus_re;

    // Monitor: pops expected words as the design returns them
    initial begin
        forever begin
            @(negedge clk);
            if (rd_pend) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL unexpected read data: actual=%h expected=none", bus_rdata);
                end else begin
                    logic [15:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (bus_rdata !== e) begin
                        bad++;
                        $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic program_word(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        bus_write(a, 16'h1010);
        bus_write(a, d);
        idle_cycles(BUSY + 2);
        bus_write(a, 16'hFFFF);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: erased array after reset
        bus_read(8'h00, 16'hFFFF, "R1 R2 array after reset");
        bus_read(8'hFF, 16'hFFFF, "R1 R2 top word after reset");

        // R6 / R1: clear status, status word 0x0080
        bus_write(8'h00, 16'h5050);
        bus_read(8'h40, 16'h0080, "R1 R6 status after clear");

        // R7: back to array
        bus_write(8'h00, 16'hFFFF);
        bus_read(8'h10, 16'hFFFF, "R7 array after read command");

        // R8 / R9: program with per-cycle polling
        bus_write(8'h12, 16'h1010);
        bus_read(8'h12, 16'h0080, "R8 status in program setup");
        bus_write(8'h12, 16'h1234);
        for (int k = 0; k <= BUSY; k++) begin
            bus_read(8'h12, (k < BUSY) ? 16'h0000 : 16'h0080, "R9 busy window");
        end
        bus_read(8'h77, 16'h0080, "R8 status at other address");
        bus_write(8'h12, 16'hFFFF);
        bus_read(8'h12, 16'h1234, "R3 first program");

        // R3: second program only clears bits
        program_word(8'h12, 16'hFF0F);
        bus_read(8'h12, 16'h1204, "R3 program ANDs");

        // set up words around block 2 (0x20..0x2F)
        program_word(8'h25, 16'h0F0F);
        program_word(8'h2F, 16'hAAAA);
        program_word(8'h30, 16'h5555);
        program_word(8'h1F, 16'h3333);
        bus_read(8'h2F, 16'hAAAA, "R3 program block edge");

        // R4 / R10: erase with writes landing in the busy window
        bus_write(8'h21, 16'h2020);
        bus_read(8'h21, 16'h0080, "R8 status in erase setup");
        bus_write(8'h21, 16'hD0D0);
        bus_write(8'h00, 16'hFFFF);
        bus_read(8'h00, 16'h0000, "R10 read command ignored while busy");
        bus_write(8'h05, 16'h1010);
        idle_cycles(BUSY);
        bus_read(8'h05, 16'h0080, "R10 status after busy");
        bus_write(8'h00, 16'hFFFF);
        bus_read(8'h05, 16'hFFFF, "R10 setup ignored while busy");
        bus_read(8'h25, 16'hFFFF, "R4 erased word");
        bus_read(8'h2F, 16'hFFFF, "R4 erased last word of block");
        bus_read(8'h30, 16'h5555, "R4 next block untouched");
        bus_read(8'h1F, 16'h3333, "R4 previous block untouched");
        bus_read(8'h12, 16'h1204, "R4 far block untouched");

        // R5: aborted erase
        bus_write(8'h12, 16'h2020);
        bus_write(8'h12, 16'h1234);
        bus_read(8'h00, 16'h00A0, "R5 abort flag set");
        bus_write(8'h00, 16'hFFFF);
        bus_read(8'h12, 16'h1204, "R5 array unchanged");
        bus_read(8'h10, 16'hFFFF, "R5 block untouched");

        // R6: clear removes the abort flag
        bus_write(8'h00, 16'h5050);
        bus_read(8'h00, 16'h0080, "R6 abort flag cleared");

        // R11: unknown words ignored in status mode and array mode
        bus_write(8'h30, 16'h4444);
        bus_read(8'h30, 16'h0080, "R11 status mode kept");
        bus_write(8'h00, 16'hFFFF);
        bus_write(8'h12, 16'hD0D0);
        bus_read(8'h12, 16'h1204, "R11 lone confirm ignored");
        bus_write(8'h30, 16'h1234);
        bus_read(8'h30, 16'h5555, "R11 data word ignored");

        idle_cycles(3);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R2 missing reads: actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R9: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule